// File: doc/BRIEF.md
# Key Cache Register Table

This block is a 64-slot table of WEP key records that a host programs through a single-cycle register strobe. Each slot has eight 32-bit words. The host selects a slot and a word and writes or reads it. Five words carry key material, one word carries the key length class, and two words carry the shifted station address together with a live flag.

Key material is held in two 48-bit pair registers plus one 32-bit tail word. A write to the even word of a pair goes into a single staging register. The pair is stored only when the matching odd word is written, and a staged word never appears on readback.

A lookup port takes a 48-bit station address. One cycle later it returns the lowest live slot whose stored address matches, together with that slot's assembled 128-bit key and its type.

Top module: `wep_keytab`

## Requirements
- R1: A slot index of 64 or more is ignored. Such a write changes no slot and leaves the staging register untouched, and such a read returns zero.
- R2: Word select codes are 0 KEY0, 1 KEY1, 2 KEY2, 3 KEY3, 4 KEY4, 5 TYPE, 6 MAC0 and 7 MAC1. KEY1, KEY3 and MAC1 read back their low 16 bits only, TYPE reads back its low 2 bits only, and all other bits read as zero.
- R3: A write to KEY0 or KEY2 only stages the word, and readback still shows the old stored value. A later write to the odd partner (KEY1 or KEY3) of the same slot stores the staged word together with the odd word in one step.
- R4: If no matching stage exists for the same slot and pair, an odd write stores its pair with the low word zero. Any in-range even write replaces the staged word, and every odd write leaves the staging register empty.
- R5: MAC0 holds address bits 32:1. MAC1 bits 14:0 hold address bits 47:33, and MAC1 bit 15 is the slot's live flag.
- R6: The lookup key is {KEY4, KEY3[15:0], KEY2, KEY1[15:0], KEY0}, with key byte 0 in bits 7:0. TYPE 0 means a 40-bit key, 1 means 104-bit and 3 means 128-bit. For any TYPE other than 3, key bits 127:104 read as zero.
- R7: A lookup compares address bits 47:1 against live slots only, so address bit 0 and slots without the live flag never affect the result.
- R8: When several live slots match, the lowest slot index is reported.
- R9: The lookup result appears in the cycle after the request, marked by lk_done. On a miss, hit, index, key and type are all zero.
- R10: After reset every word of every slot is zero and no slot is live. Writing zero to all eight words of a slot returns it to that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_slot | input | 8 | Slot index for the write and readback |
| reg_sel | input | 3 | Word select within the slot |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Stored contents of the selected word |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 48 | Station address to look up |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A live slot matched |
| lk_idx | output | 6 | Index of the matching slot |
| lk_key | output | 128 | Assembled key of the matching slot |
| lk_type | output | 2 | Key type of the matching slot |

## Verification
A vector table drives write and read sequences that tell a completed pair apart from three other cases: a staged word that was never committed, an orphan odd write, and a stage displaced by another slot. Out-of-range writes are placed between a stage and its commit, which shows that they do not disturb the pending word. Directed lookups use two live slots with the same address to expose priority, and an address differing only in bit 0 to expose the shift. A matching slot without the live flag must miss. The same slot is looked up under TYPE 0 and TYPE 3 to separate masked from full key tails.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

  typedef enum logic [2:0] {
    SEL_KEY0 = 3'd0,
    SEL_KEY1 = 3'd1,
    SEL_KEY2 = 3'd2,
    SEL_KEY3 = 3'd3,
    SEL_KEY4 = 3'd4,
    SEL_TYPE = 3'd5,
    SEL_MAC0 = 3'd6,
    SEL_MAC1 = 3'd7
  } word_sel_e;

  localparam logic [1:0] KT_FULL = 2'd3;

  // One slot: pairs are {odd[15:0], even[31:0]}
  typedef struct packed {
    logic [47:0] pair_hi;
    logic [47:0] pair_lo;
    logic [31:0] tail;
    logic [1:0]  ktype;
    logic [31:0] mac_lo;
    logic        live;
    logic [14:0] mac_hi;
  } slot_t;

  function automatic logic [46:0] addr_tag(input logic [47:0] addr);
    return addr[47:1];
  endfunction

  function automatic logic [46:0] slot_tag(input slot_t s);
    return {s.mac_hi, s.mac_lo};
  endfunction

  function automatic logic [127:0] slot_key(input slot_t s);
    logic [31:0] t;
    t = (s.ktype == KT_FULL) ? s.tail : {24'h0, s.tail[7:0]};
    return {t, s.pair_hi, s.pair_lo};
  endfunction

  function automatic logic [31:0] slot_word(input slot_t s, input logic [2:0] sel);
    logic [31:0] w;
    case (sel)
      SEL_KEY0: w = s.pair_lo[31:0];
      SEL_KEY1: w = {16'h0, s.pair_lo[47:32]};
      SEL_KEY2: w = s.pair_hi[31:0];
      SEL_KEY3: w = {16'h0, s.pair_hi[47:32]};
      SEL_KEY4: w = s.tail;
      SEL_TYPE: w = {30'h0, s.ktype};
      SEL_MAC0: w = s.mac_lo;
      default:  w = {16'h0, s.live, s.mac_hi};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/wkt_stage.sv
module wkt_stage #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  output logic              stage_evt,
  output logic              commit_evt,
  output logic              commit_hi,
  output logic [31:0]       commit_low,
  output logic              pend_live
);
  import wkt_pkg::*;

  logic              pend_hi_q;
  logic [SLOT_W-1:0] pend_slot_q;
  logic [31:0]       pend_word_q;
  logic              is_even;
  logic              is_odd;
  logic              pend_match;

  assign is_even    = (sel == SEL_KEY0) || (sel == SEL_KEY2);
  assign is_odd     = (sel == SEL_KEY1) || (sel == SEL_KEY3);
  assign stage_evt  = wr_ok && is_even;
  assign commit_evt = wr_ok && is_odd;
  assign commit_hi  = sel[1];
  assign pend_match = pend_live && (pend_slot_q == slot) && (pend_hi_q == sel[1]);
  assign commit_low = pend_match ? pend_word_q : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_live   <= 1'b0;
      pend_hi_q   <= 1'b0;
      pend_slot_q <= '0;
      pend_word_q <= '0;
    end else if (stage_evt) begin
      pend_live   <= 1'b1;
      pend_hi_q   <= sel[1];
      pend_slot_q <= slot;
      pend_word_q <= wdata;
    end else if (commit_evt) begin
      pend_live   <= 1'b0;
    end
  end

endmodule

// File: rtl/wkt_store.sv
module wkt_store #(
  parameter int N      = 64,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        sel,
  input  logic [31:0]       wdata,
  input  logic              commit_evt,
  input  logic              commit_hi,
  input  logic [31:0]       commit_low,
  output wkt_pkg::slot_t    tbl [N]
);
  import wkt_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic here;
    assign here = wr_ok && (slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[g] <= '0;
      end else if (here) begin
        if (commit_evt) begin
          if (commit_hi) tbl[g].pair_hi <= {wdata[15:0], commit_low};
          else           tbl[g].pair_lo <= {wdata[15:0], commit_low};
        end else begin
          case (sel)
            SEL_KEY4: tbl[g].tail   <= wdata;
            SEL_TYPE: tbl[g].ktype  <= wdata[1:0];
            SEL_MAC0: tbl[g].mac_lo <= wdata;
            SEL_MAC1: begin
              tbl[g].live   <= wdata[15];
              tbl[g].mac_hi <= wdata[14:0];
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/wkt_match.sv
module wkt_match #(
  parameter int N      = 64,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [47:0]       lk_addr,
  input  wkt_pkg::slot_t    tbl [N],
  output logic              lk_done,
  output logic              lk_hit,
  output logic [SLOT_W-1:0] lk_idx,
  output logic [127:0]      lk_key,
  output logic [1:0]        lk_type
);
  import wkt_pkg::*;

  logic [N-1:0]      hit_vec;
  logic              any_hit;
  logic [SLOT_W-1:0] win_idx;
  logic [46:0]       want;

  assign want = addr_tag(lk_addr);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = tbl[g].live && (slot_tag(tbl[g]) == want);
  end

  always_comb begin
    any_hit = |hit_vec;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = SLOT_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_idx  <= '0;
      lk_key  <= '0;
      lk_type <= '0;
    end else begin
      lk_done <= lk_req;
      if (lk_req && any_hit) begin
        lk_hit  <= 1'b1;
        lk_idx  <= win_idx;
        lk_key  <= slot_key(tbl[win_idx]);
        lk_type <= tbl[win_idx].ktype;
      end else begin
        lk_hit  <= 1'b0;
        lk_idx  <= '0;
        lk_key  <= '0;
        lk_type <= '0;
      end
    end
  end

endmodule

// File: rtl/wep_keytab.sv
module wep_keytab #(
  parameter int N       = 64,
  parameter int ENTRY_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ENTRY_W-1:0]   reg_slot,
  input  logic [2:0]           reg_sel,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 lk_req,
  input  logic [47:0]          lk_addr,
  output logic                 lk_done,
  output logic                 lk_hit,
  output logic [$clog2(N)-1:0] lk_idx,
  output logic [127:0]         lk_key,
  output logic [1:0]           lk_type
);
  import wkt_pkg::*;

  localparam int SLOT_W = $clog2(N);

  logic              in_range;
  logic              wr_ok;
  logic [SLOT_W-1:0] slot;
  logic              stage_evt;
  logic              commit_evt;
  logic              commit_hi;
  logic [31:0]       commit_low;
  logic              pend_live;
  slot_t             tbl [N];

  assign in_range  = ({1'b0, reg_slot} < (ENTRY_W + 1)'(N));
  assign wr_ok     = reg_wr && in_range;
  assign slot      = reg_slot[SLOT_W-1:0];
  assign reg_rdata = in_range ? slot_word(tbl[slot], reg_sel) : 32'h0;

  wkt_stage #(.SLOT_W(SLOT_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .slot(slot), .sel(reg_sel),
    .wdata(reg_wdata), .stage_evt(stage_evt), .commit_evt(commit_evt),
    .commit_hi(commit_hi), .commit_low(commit_low), .pend_live(pend_live)
  );

  wkt_store #(.N(N), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .slot(slot), .sel(reg_sel),
    .wdata(reg_wdata), .commit_evt(commit_evt), .commit_hi(commit_hi),
    .commit_low(commit_low), .tbl(tbl)
  );

  wkt_match #(.N(N), .SLOT_W(SLOT_W)) u_match (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr), .tbl(tbl),
    .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_key(lk_key),
    .lk_type(lk_type)
  );

endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
  parameter int N       = 64,
  parameter int ENTRY_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ENTRY_W-1:0] reg_slot,
  input logic               stage_evt,
  input logic               commit_evt,
  input logic               pend_live,
  input logic               lk_req,
  input logic               lk_done,
  input logic               lk_hit,
  input logic [127:0]       lk_key,
  input logic [1:0]         lk_type
);

  AST_RANGE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ({1'b0, reg_slot} >= (ENTRY_W + 1)'(N))) |-> !(stage_evt || commit_evt)); // R1

  AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    stage_evt |=> pend_live); // R3

  AST_STAGE_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !pend_live); // R4

  AST_SHORT_KEY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_type != 2'd3) |-> (lk_key[127:104] == 24'h0)); // R6

  AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> lk_done); // R9

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !lk_done); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_done && !lk_hit) |-> (lk_key == 128'h0 && lk_type == 2'd0)); // R9

  AST_HIT_ONLY_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_done); // R9

endmodule

bind wep_keytab wkt_checker #(.N(N), .ENTRY_W(ENTRY_W)) u_wkt_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_slot(reg_slot),
  .stage_evt(stage_evt), .commit_evt(commit_evt), .pend_live(pend_live),
  .lk_req(lk_req), .lk_done(lk_done), .lk_hit(lk_hit), .lk_key(lk_key),
  .lk_type(lk_type)
);

// File: tb/wep_keytab_bench.sv
module wep_keytab_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [7:0]   reg_slot = '0;
  logic [2:0]   reg_sel = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         lk_req = 1'b0;
  logic [47:0]  lk_addr = '0;
  logic         lk_done;
  logic         lk_hit;
  logic [5:0]   lk_idx;
  logic [127:0] lk_key;
  logic [1:0]   lk_type;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wep_keytab u_wep_keytab (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_slot(reg_slot),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_idx(lk_idx), .lk_key(lk_key), .lk_type(lk_type)
  );

  // {is_read, slot, sel, wdata, expected}
  localparam int NV = 30;
  localparam logic [75:0] VEC [NV] = '{
    {1'b0, 8'd3,  3'd0, 32'h11223344, 32'h0},        // R3
    {1'b0, 8'd3,  3'd1, 32'hAABBCCDD, 32'h0},
    {1'b1, 8'd3,  3'd0, 32'h0,        32'h11223344},
    {1'b1, 8'd3,  3'd1, 32'h0,        32'h0000CCDD}, // R2
    {1'b0, 8'd5,  3'd0, 32'hDEADBEEF, 32'h0},
    {1'b1, 8'd5,  3'd0, 32'h0,        32'h0},        // R3 hidden
    {1'b0, 8'd5,  3'd1, 32'h00001234, 32'h0},
    {1'b1, 8'd5,  3'd0, 32'h0,        32'hDEADBEEF},
    {1'b0, 8'd7,  3'd3, 32'h00005555, 32'h0},        // R4 orphan
    {1'b1, 8'd7,  3'd2, 32'h0,        32'h0},
    {1'b1, 8'd7,  3'd3, 32'h0,        32'h00005555},
    {1'b0, 8'd9,  3'd2, 32'hCAFEF00D, 32'h0},        // R4 displaced
    {1'b0, 8'd10, 3'd0, 32'h01010101, 32'h0},
    {1'b0, 8'd9,  3'd3, 32'h0000BEEF, 32'h0},
    {1'b1, 8'd9,  3'd2, 32'h0,        32'h0},
    {1'b1, 8'd10, 3'd0, 32'h0,        32'h0},
    {1'b0, 8'd11, 3'd0, 32'h77777777, 32'h0},        // R1 stage kept
    {1'b0, 8'd70, 3'd0, 32'h12345678, 32'h0},
    {1'b0, 8'd11, 3'd1, 32'h00000001, 32'h0},
    {1'b1, 8'd11, 3'd0, 32'h0,        32'h77777777},
    {1'b0, 8'd64, 3'd4, 32'hFFFFFFFF, 32'h0},        // R1
    {1'b1, 8'd64, 3'd4, 32'h0,        32'h0},
    {1'b1, 8'd0,  3'd4, 32'h0,        32'h0},
    {1'b0, 8'd12, 3'd7, 32'hFFFFFFFF, 32'h0},        // R2
    {1'b1, 8'd12, 3'd7, 32'h0,        32'h0000FFFF},
    {1'b0, 8'd12, 3'd5, 32'hFFFFFFFF, 32'h0},
    {1'b1, 8'd12, 3'd5, 32'h0,        32'h00000003},
    {1'b0, 8'd13, 3'd0, 32'hAAAA0000, 32'h0},        // R4 wrong pair
    {1'b0, 8'd13, 3'd3, 32'h00000022, 32'h0},
    {1'b1, 8'd13, 3'd2, 32'h0,        32'h0}
  };
  localparam string VTAG [NV] = '{
    "R3", "R3", "R3", "R2", "R3", "R3", "R3", "R3", "R4", "R4",
    "R4", "R4", "R4", "R4", "R4", "R4", "R1", "R1", "R1", "R1",
    "R1", "R1", "R1", "R2", "R2", "R2", "R2", "R4", "R4", "R4"
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] s, input logic [2:0] sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_slot = s; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] s, input logic [2:0] sel,
                    input logic [31:0] exp);
    reg_wr = 1'b0; reg_slot = s; reg_sel = sel;
    #1;
    check(tag, {96'h0, reg_rdata}, {96'h0, exp});
    @(negedge clk);
  endtask

  task automatic set_mac(input logic [7:0] s, input logic [47:0] a, input logic live);
    logic [47:0] sh;
    sh = a >> 1;
    wr(s, 3'd6, sh[31:0]);
    wr(s, 3'd7, {16'h0, live, sh[46:32]});
  endtask

  task automatic look(input string tag, input logic [47:0] a, input logic hit,
                      input logic [5:0] idx, input logic [127:0] key, input logic [1:0] ty);
    lk_req = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    check({tag, " done"}, {127'h0, lk_done}, 128'h1);
    check({tag, " hit"},  {127'h0, lk_hit},  {127'h0, hit});
    check({tag, " idx"},  {122'h0, lk_idx},  {122'h0, idx});
    check({tag, " key"},  lk_key, key);
    check({tag, " type"}, {126'h0, lk_type}, {126'h0, ty});
  endtask

  localparam logic [47:0] MAC_A = 48'h0A1B2C3D4E5F;
  localparam logic [47:0] MAC_B = 48'h665544332210;
  localparam logic [127:0] KEY_SHORT =
    {32'h000000FF, 16'h0B0A, 32'h09080706, 16'h0504, 32'h03020100};
  localparam logic [127:0] KEY_FULL =
    {32'hFFFFFFFF, 16'h0B0A, 32'h09080706, 16'h0504, 32'h03020100};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd("R10 reset MAC1", 8'd0, 3'd7, 32'h0);
    rd("R10 reset KEY2", 8'd63, 3'd2, 32'h0);
    look("R10 reset lookup", 48'h0, 1'b0, 6'd0, 128'h0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][75]) rd(VTAG[i], VEC[i][74:67], VEC[i][66:64], VEC[i][31:0]);
      else            wr(VEC[i][74:67], VEC[i][66:64], VEC[i][63:32]);
    end

    // R5 address layout
    set_mac(8'd30, MAC_A, 1'b1);
    rd("R5 MAC0", 8'd30, 3'd6, MAC_A[32:1]);
    rd("R5 MAC1", 8'd30, 3'd7, {16'h0, 1'b1, MAC_A[47:33]});

    // R8 priority: slot 20 below slot 30
    set_mac(8'd20, MAC_A, 1'b1);
    wr(8'd20, 3'd5, 32'd1);
    look("R8 lowest wins", MAC_A, 1'b1, 6'd20, 128'h0, 2'd1);
    // R7 bit 0 ignored
    look("R7 bit0", MAC_A ^ 48'h1, 1'b1, 6'd20, 128'h0, 2'd1);

    // R10 clear slot 20 by zeros
    for (int w = 0; w < 8; w++) wr(8'd20, w[2:0], 32'h0);
    rd("R10 cleared MAC1", 8'd20, 3'd7, 32'h0);
    rd("R10 cleared TYPE", 8'd20, 3'd5, 32'h0);
    look("R10 after clear", MAC_A, 1'b1, 6'd30, 128'h0, 2'd0);

    // R7 not-live slot never hits
    set_mac(8'd41, MAC_B, 1'b0);
    look("R7 not live", MAC_B, 1'b0, 6'd0, 128'h0, 2'd0);

    // R6 key layout and tail mask
    wr(8'd40, 3'd0, 32'h03020100);
    wr(8'd40, 3'd1, 32'hFFFF0504);
    wr(8'd40, 3'd2, 32'h09080706);
    wr(8'd40, 3'd3, 32'h00000B0A);
    wr(8'd40, 3'd4, 32'hFFFFFFFF);
    wr(8'd40, 3'd5, 32'd0);
    set_mac(8'd40, MAC_B, 1'b1);
    look("R6 40-bit", MAC_B, 1'b1, 6'd40, KEY_SHORT, 2'd0);
    wr(8'd40, 3'd5, 32'd3);
    look("R6 128-bit", MAC_B, 1'b1, 6'd40, KEY_FULL, 2'd3);

    // R9 no request -> no done
    @(negedge clk);
    check("R9 idle done", {127'h0, lk_done}, 128'h0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule